// File: doc/BRIEF.md
# Ethernet receive frame filter

This block sits behind a receive adapter that has already removed the preamble and start delimiter. It takes one received frame as a byte stream. Each byte has a valid strobe, a last marker and an error flag from the physical layer. The block checks the destination address, runs the frame check sequence, and holds back the four check bytes so they never reach the consumer. It writes the remaining bytes into a packet buffer, and the consumer drains that buffer through a ready/valid stream with a last marker.

A frame is written speculatively. It becomes visible at the output only after its final byte has arrived and every check has passed. Otherwise it is erased by winding the write pointer back. The block drops a frame for one of four reasons: a physical-layer error, an address that does not pass the filter, a buffer too full to hold the frame, or a bad check sequence. It reports the first reason seen on one of four single-cycle pulse outputs. The buffer depth must be a power of two.

Top module: `rxf_frame_filter`

## Requirements
- R1: An accepted frame appears at the output as every received byte except the final four, in arrival order. `out_last` is high on the last of these bytes only. No byte of a frame is presented before that frame's final input byte has been accepted.
- R2: The first six bytes are the destination address, first byte on the wire first. The frame passes the filter when these bytes equal `STATION_ADDR` (default 01:23:45:67:89:AB, most significant byte first on the wire) or are all 0xFF. Otherwise, or when the frame ends before its sixth byte, the frame is dropped with `drop_addr`.
- R3: The check sequence is CRC-32 with polynomial 0x04C11DB7, reflected in and out, seeded with 0xFFFFFFFF. It is sent as the complemented CRC, least significant byte first. A frame is good when the reflected register run over all its bytes ends at 0xDEBB20E3. Otherwise the frame is dropped with `drop_fcs`.
- R4: A frame in which any accepted byte has `rx_err` high is dropped with `drop_phy`.
- R5: The buffer holds `DEPTH` bytes in total, counting unread accepted bytes plus the bytes of the frame now arriving. A byte that would exceed this drops the frame with `drop_oom`. A frame that fills the buffer exactly is accepted.
- R6: A drop pulse is high for exactly one cycle, the cycle after the frame's final byte is accepted. At most one pulse is high. The reported reason is the one detected at the earliest byte. A physical-layer error is detected at its byte, the address at byte six (or at the end of a short frame), a full buffer at the rejected write, and the check sequence at the final byte. When reasons tie on the same byte, the priority is physical error, then address, then buffer, then check sequence.
- R7: A dropped frame leaves nothing in the buffer. Frames accepted before it and after it come out intact.
- R8: Cycles with `rx_valid` low are ignored, whatever `rx_last`, `rx_err` and `rx_data` carry, including gaps inside a frame.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R10: After reset, `out_valid` and all drop pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 1 | Physical-layer error on this byte |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final payload byte of the frame |
| out_ready | input | 1 | Consumer accepts the byte |
| drop_phy | output | 1 | Frame dropped: physical-layer error |
| drop_addr | output | 1 | Frame dropped: address filter |
| drop_oom | output | 1 | Frame dropped: buffer full |
| drop_fcs | output | 1 | Frame dropped: bad check sequence |

## Verification
The hardest case to reach is a buffer overflow on an exact boundary. One frame has to fill the buffer to the last byte and be accepted, while the next one overflows at a predictable byte.

The stimulus holds `out_ready` low so that occupancy is fully known. It commits a 40-byte frame into a 64-entry buffer, then sends a 30-byte frame that must fail at its 25th write, then a 24-byte frame that must fit exactly. Further frames then race a full buffer against a bad check sequence and against an earlier physical-layer error, which exercises the earliest-detection ordering.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

    localparam int BYTE_W    = 8;
    localparam int FCS_BYTES = 4;
    localparam int MAC_BYTES = 6;

    localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

    typedef enum logic [2:0] {
        RSN_NONE,
        RSN_PHY,
        RSN_ADDR,
        RSN_OOM,
        RSN_FCS
    } drop_rsn_e;

    typedef struct packed {
        logic phy;
        logic addr;
        logic oom;
        logic fcs;
    } drop_vec_t;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } buf_word_t;

    // One byte through the reflected CRC-32 register, LSB of the byte first.
    function automatic logic [31:0] crc_step(input logic [31:0] c,
                                             input logic [BYTE_W-1:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Tie-break among reasons detected on the same byte.
    function automatic drop_rsn_e first_reason(input drop_vec_t v);
        drop_rsn_e r;
        if (v.phy)       r = RSN_PHY;
        else if (v.addr) r = RSN_ADDR;
        else if (v.oom)  r = RSN_OOM;
        else if (v.fcs)  r = RSN_FCS;
        else             r = RSN_NONE;
        return r;
    endfunction

    function automatic drop_vec_t reason_vec(input drop_rsn_e r);
        drop_vec_t v;
        v = '0;
        case (r)
            RSN_PHY:  v.phy  = 1'b1;
            RSN_ADDR: v.addr = 1'b1;
            RSN_OOM:  v.oom  = 1'b1;
            RSN_FCS:  v.fcs  = 1'b1;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rxf_crc.sv
`timescale 1ns/1ps
module rxf_crc
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              first,
    input  logic [BYTE_W-1:0] data,
    output logic              residue_ok
);

    logic [31:0] crc_q;
    logic [31:0] crc_nx;

    // The register restarts from the seed on the first byte of every frame.
    assign crc_nx     = crc_step(first ? CRC_SEED : crc_q, data);
    assign residue_ok = (crc_nx == CRC_RESIDUE);

    always_ff @(posedge clk) begin
        if (rst)       crc_q <= CRC_SEED;
        else if (step) crc_q <= crc_nx;
    end

endmodule

// File: rtl/rxf_addr_match.sv
`timescale 1ns/1ps
module rxf_addr_match
    import rxf_pkg::*;
#(
    parameter int                     CNT_W        = 3,
    parameter logic [8*MAC_BYTES-1:0] STATION_ADDR = 48'h0123_4567_89AB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [CNT_W-1:0]  idx,
    input  logic [BYTE_W-1:0] data,
    output logic              mismatch_now
);

    logic [MAC_BYTES-1:0][BYTE_W-1:0] stn_byte;

    // Wire order: most significant address byte arrives first.
    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_stn
        assign stn_byte[g] = STATION_ADDR[BYTE_W*(MAC_BYTES-1-g) +: BYTE_W];
    end

    logic              stn_q, bc_q;
    logic              stn_nx, bc_nx;
    logic              in_addr;
    logic [BYTE_W-1:0] want;

    always_comb begin
        want = '0;
        for (int i = 0; i < MAC_BYTES; i++) begin
            if (idx == CNT_W'(i)) want = stn_byte[i];
        end
        in_addr = (idx < CNT_W'(MAC_BYTES));
        stn_nx  = ((idx == '0) ? 1'b1 : stn_q) && (data == want);
        bc_nx   = ((idx == '0) ? 1'b1 : bc_q)  && (data == {BYTE_W{1'b1}});
        mismatch_now = step && (idx == CNT_W'(MAC_BYTES-1)) && !(stn_nx || bc_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stn_q <= 1'b0;
            bc_q  <= 1'b0;
        end else if (step && in_addr) begin
            stn_q <= stn_nx;
            bc_q  <= bc_nx;
        end
    end

endmodule

// File: rtl/rxf_fcs_delay.sv
`timescale 1ns/1ps
module rxf_fcs_delay
    import rxf_pkg::*;
#(
    parameter int DLY = FCS_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              frame_end,
    input  logic [BYTE_W-1:0] data,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_data
);

    localparam int FILL_W = $clog2(DLY + 1);

    logic [BYTE_W-1:0] line [DLY];
    logic [FILL_W-1:0] fill;

    // A byte leaves only once DLY younger bytes stand behind it, so the
    // trailing check bytes are still inside the line when the frame ends.
    assign pop_valid = step && (fill == FILL_W'(DLY));
    assign pop_data  = line[DLY-1];

    always_ff @(posedge clk) begin
        if (step) begin
            line[0] <= data;
            for (int i = 1; i < DLY; i++) line[i] <= line[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        fill <= '0;
        else if (step && frame_end)     fill <= '0;
        else if (step && fill != FILL_W'(DLY)) fill <= fill + 1'b1;
    end

endmodule

// File: rtl/rxf_pkt_buf.sv
`timescale 1ns/1ps
module rxf_pkt_buf
    import rxf_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  buf_word_t wr_word,
    input  logic      commit,
    input  logic      rollback,
    output logic      full,
    output logic      rd_valid,
    output buf_word_t rd_word,
    input  logic      rd_ready
);

    localparam int           PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] CAP = (PTR_W+1)'(DEPTH);

    buf_word_t      mem [DEPTH];
    logic [PTR_W:0] tent_q, cmt_q, rd_q;
    logic [PTR_W:0] used, cused;

    assign used     = tent_q - rd_q;
    assign cused    = cmt_q - rd_q;
    assign full     = (used == CAP);
    assign rd_valid = (rd_q != cmt_q);
    assign rd_word  = mem[rd_q[PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) mem[tent_q[PTR_W-1:0]] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tent_q <= '0;
            cmt_q  <= '0;
            rd_q   <= '0;
        end else begin
            if (rd_valid && rd_ready) rd_q <= rd_q + 1'b1;
            if (rollback) begin
                tent_q <= cmt_q;
            end else begin
                if (wr_en)  tent_q <= tent_q + 1'b1;
                if (commit) cmt_q  <= tent_q + {{PTR_W{1'b0}}, wr_en};
            end
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        used <= CAP);

    // R7
    commit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cused <= used);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_word));

endmodule

// File: rtl/rxf_frame_filter.sv
`timescale 1ns/1ps
module rxf_frame_filter
    import rxf_pkg::*;
#(
    parameter int                     DEPTH        = 2048,
    parameter logic [8*MAC_BYTES-1:0] STATION_ADDR = 48'h0123_4567_89AB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              drop_phy,
    output logic              drop_addr,
    output logic              drop_oom,
    output logic              drop_fcs
);

    localparam int CNT_MAX = MAC_BYTES + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic              fend;
    logic [CNT_W-1:0]  byte_cnt;
    logic              crc_ok, addr_miss, addr_bad;
    logic              pop_valid;
    logic [BYTE_W-1:0] pop_data;
    logic              buf_full, buf_wr, commit, rollback;
    drop_rsn_e         rsn_q, rsn_now, rsn_eff;
    drop_vec_t         det, pulse_q;
    buf_word_t         wr_word, rd_word;

    assign fend = rx_valid && rx_last;

    // Byte position in the frame, saturating past the address field.
    always_ff @(posedge clk) begin
        if (rst)                                        byte_cnt <= '0;
        else if (fend)                                  byte_cnt <= '0;
        else if (rx_valid && byte_cnt != CNT_W'(CNT_MAX)) byte_cnt <= byte_cnt + 1'b1;
    end

    rxf_crc u_crc (
        .clk        (clk),
        .rst        (rst),
        .step       (rx_valid),
        .first      (byte_cnt == '0),
        .data       (rx_data),
        .residue_ok (crc_ok)
    );

    rxf_addr_match #(
        .CNT_W        (CNT_W),
        .STATION_ADDR (STATION_ADDR)
    ) u_addr (
        .clk          (clk),
        .rst          (rst),
        .step         (rx_valid),
        .idx          (byte_cnt),
        .data         (rx_data),
        .mismatch_now (addr_miss)
    );

    rxf_fcs_delay #(
        .DLY (FCS_BYTES)
    ) u_dly (
        .clk       (clk),
        .rst       (rst),
        .step      (rx_valid),
        .frame_end (fend),
        .data      (rx_data),
        .pop_valid (pop_valid),
        .pop_data  (pop_data)
    );

    // Reasons detected on the current byte; the earliest one is latched.
    always_comb begin
        addr_bad = addr_miss || (fend && byte_cnt < CNT_W'(MAC_BYTES-1));
        buf_wr   = pop_valid && !buf_full && (rsn_q == RSN_NONE);
        det      = '{phy:  rx_valid && rx_err,
                     addr: addr_bad,
                     oom:  pop_valid && buf_full && (rsn_q == RSN_NONE),
                     fcs:  fend && !crc_ok};
        rsn_now  = first_reason(det);
        rsn_eff  = (rsn_q != RSN_NONE) ? rsn_q : rsn_now;
        commit   = fend && (rsn_eff == RSN_NONE);
        rollback = fend && (rsn_eff != RSN_NONE);
        wr_word  = '{last: fend, data: pop_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsn_q   <= RSN_NONE;
            pulse_q <= '0;
        end else begin
            pulse_q <= '0;
            if (fend) begin
                pulse_q <= reason_vec(rsn_eff);
                rsn_q   <= RSN_NONE;
            end else if (rx_valid && rsn_q == RSN_NONE) begin
                rsn_q <= rsn_now;
            end
        end
    end

    rxf_pkt_buf #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (buf_wr),
        .wr_word  (wr_word),
        .commit   (commit),
        .rollback (rollback),
        .full     (buf_full),
        .rd_valid (out_valid),
        .rd_word  (rd_word),
        .rd_ready (out_ready)
    );

    assign out_data  = rd_word.data;
    assign out_last  = rd_word.last;
    assign drop_phy  = pulse_q.phy;
    assign drop_addr = pulse_q.addr;
    assign drop_oom  = pulse_q.oom;
    assign drop_fcs  = pulse_q.fcs;

    // R6
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drop_phy, drop_addr, drop_oom, drop_fcs}));

    // R6
    pulse_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_phy || drop_addr || drop_oom || drop_fcs) |-> $past(rx_valid && rx_last));

    // R1
    fcs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> byte_cnt >= CNT_W'(FCS_BYTES));

    // R1
    commit_visible_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(commit));

endmodule

// File: tb/rxf_frame_filter_tb.sv
`timescale 1ns/1ps
module rxf_frame_filter_tb;

    localparam int          DEPTH = 64;
    localparam logic [47:0] STN   = 48'h0123_4567_89AB;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_last = 1'b0;
    logic       rx_err = 1'b0;
    logic       out_valid, out_last;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       drop_phy, drop_addr, drop_oom, drop_fcs;

    always #2 clk = ~clk;

    rxf_frame_filter #(.DEPTH(DEPTH), .STATION_ADDR(STN)) u_dut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .drop_phy(drop_phy), .drop_addr(drop_addr), .drop_oom(drop_oom), .drop_fcs(drop_fcs)
    );

    int         checks = 0;
    int         fails  = 0;
    int         cyc    = 0;
    int         rdy_mode = 0;
    logic [3:0] sched = 4'b0;
    logic [3:0] pend;
    logic [3:0] act;
    logic [8:0] exp_q[$];
    logic [8:0] w;
    logic       hold_pend = 1'b0;
    logic [8:0] hold_word;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint a, input longint e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
        end
    endtask

    function automatic string tag(input logic [3:0] v);
        if (v[3]) return "R4";
        if (v[2]) return "R2";
        if (v[1]) return "R5";
        if (v[0]) return "R3";
        return "R6";
    endfunction

    function automatic logic [31:0] ref_crc(input bq_t b);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        foreach (b[i]) begin
            c = c ^ {24'h0, b[i]};
            repeat (8) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic [7:0] stn_b(input int i);
        return 8'(STN >> (40 - 8*i));
    endfunction

    // kind 0: station, 1: broadcast, 2: station with last byte altered
    function automatic bq_t mk(input int kind, input int plen, input int seed, input bit bad);
        bq_t f;
        logic [31:0] c;
        for (int i = 0; i < 6; i++)
            f.push_back(kind == 1 ? 8'hFF : (kind == 2 && i == 5) ? 8'hAA : stn_b(i));
        for (int i = 6; i < plen; i++) f.push_back(8'(seed + i*13));
        c = ~ref_crc(f);
        for (int i = 0; i < 4; i++) f.push_back(c[8*i +: 8]);
        if (bad) f[f.size()-1] = f[f.size()-1] ^ 8'h80;
        return f;
    endfunction

    // Predicts the outcome from the requirements, then drives the frame.
    task automatic send(input bq_t fr, input int err_idx, input int gap);
        int n, p, avail, best;
        int idx[4];
        bit st, bc;
        logic [3:0] vec;
        n = fr.size();
        p = n - 4;
        for (int k = 0; k < 4; k++) idx[k] = 1 << 30;
        if (err_idx >= 0) idx[0] = err_idx;
        if (n < 6) idx[1] = n - 1;
        else begin
            st = 1; bc = 1;
            for (int i = 0; i < 6; i++) begin
                if (fr[i] != stn_b(i)) st = 0;
                if (fr[i] != 8'hFF)    bc = 0;
            end
            if (!(st || bc)) idx[1] = 5;
        end
        avail = DEPTH - exp_q.size();
        if (p > avail) idx[2] = avail + 4;
        if (ref_crc(fr) != 32'hDEBB_20E3) idx[3] = n - 1;
        best = 1 << 30;
        for (int k = 0; k < 4; k++) if (idx[k] < best) best = idx[k];
        vec = 4'b0;
        for (int k = 0; k < 4; k++)
            if (vec == 4'b0 && idx[k] == best && best < (1 << 30)) vec[3-k] = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gap > 0 && i > 0 && (i % gap) == 0) begin
                rx_valid = 1'b0; rx_err = 1'b1; rx_last = 1'b1; rx_data = 8'h5A;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_data  = fr[i];
            rx_last  = (i == n - 1);
            rx_err   = (i == err_idx);
            if (i == n - 1) begin
                sched = vec;
                if (vec == 4'b0)
                    for (int j = 0; j < p; j++) exp_q.push_back({j == p - 1, fr[j]});
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic drain();
        rdy_mode = 0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Per-clock comparison against the model.
    always @(posedge clk) begin
        pend  = sched;
        sched = 4'b0;
        cyc++;
        #0.5;
        if (!rst) begin
            act = {drop_phy, drop_addr, drop_oom, drop_fcs};
            chk(act == pend, tag(pend), "drop pulses", act, pend);
            if (hold_pend)
                chk(out_valid && {out_last, out_data} == hold_word, "R9",
                    "stalled output changed", {out_valid, out_last, out_data}, {1'b1, hold_word});
        end
        case (rdy_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = cyc[0];
            default: out_ready = 1'b0;
        endcase
        #0.5;
        hold_pend = 1'b0;
        if (!rst && out_valid) begin
            if (out_ready) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R7", "byte from no accepted frame", {out_last, out_data}, 0);
                else begin
                    w = exp_q.pop_front();
                    chk({out_last, out_data} == w, "R1", "output byte", {out_last, out_data}, w);
                end
            end else begin
                hold_pend = 1'b1;
                hold_word = {out_last, out_data};
            end
        end
    end

    initial begin
        #600000;
        checks++; fails++;
        $display("FAIL R6 watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bq_t f;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        chk(!out_valid, "R10", "out_valid after reset", out_valid, 0);
        chk({drop_phy, drop_addr, drop_oom, drop_fcs} == 4'b0, "R10", "pulses after reset",
            {drop_phy, drop_addr, drop_oom, drop_fcs}, 0);

        // R1 station frame, R2 broadcast and near-miss address
        send(mk(0, 16, 3, 0), -1, 0);
        send(mk(1, 10, 7, 0), -1, 0);
        send(mk(2, 12, 9, 0), -1, 0);
        // R3 bad check sequence
        send(mk(0, 14, 11, 1), -1, 0);
        // R4 physical error mid-frame
        send(mk(0, 14, 13, 0), 8, 0);
        // R6 ties and ordering
        send(mk(0, 12, 15, 1), 15, 0);
        send(mk(2, 12, 17, 1), -1, 0);
        send(mk(2, 12, 19, 0), 3, 0);
        f = {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        send(f, -1, 0);
        // R2 short frame
        f = {stn_b(0), stn_b(1), stn_b(2)};
        send(f, -1, 0);
        // R8 idle cycles with garbage inside a frame
        send(mk(0, 18, 21, 0), -1, 3);
        drain();

        // R9 alternating ready with an interleaved drop (R7)
        rdy_mode = 1;
        send(mk(0, 9, 23, 0), -1, 0);
        send(mk(1, 20, 25, 1), -1, 0);
        send(mk(0, 7, 27, 0), -1, 0);
        drain();

        // R5 exact occupancy with the consumer stalled
        rdy_mode = 2;
        @(negedge clk);
        send(mk(0, 40, 31, 0), -1, 0);
        send(mk(0, 30, 33, 0), -1, 0);
        send(mk(1, 24, 35, 0), -1, 0);
        send(mk(0, 10, 37, 1), -1, 0);
        send(mk(0, 10, 39, 0), 2, 0);
        repeat (3) @(negedge clk);
        chk(out_valid && exp_q.size() == DEPTH, "R5", "full buffer held", exp_q.size(), DEPTH);
        drain();

        // R7 clean after drops
        send(mk(0, 11, 41, 0), -1, 0);
        drain();
        chk(!out_valid, "R7", "buffer empty after drain", out_valid, 0);
        chk(exp_q.size() == 0, "R1", "all expected bytes seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule